// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flags

This block keeps the interrupt status word of one DMA channel. It watches register-bus writes to the channel's configuration and status addresses. It also takes single-cycle event strobes from the channel's transfer engine: completion of a work unit, an error, the start and end of a descriptor fetch, and a halt in stop flow mode. From these it keeps two flags that software can only read: the channel is running, and a descriptor fetch is in progress. It also keeps two sticky flags that software clears by writing one: completion and error.

The completion flag drives the channel's own interrupt line. The error flag drives this channel's share of a global error interrupt. An error also pulses an output that tells the address logic its current-pointer registers no longer hold valid contents. Software must judge that a transfer has finished from the completion flag and not from the running flag, because on a memory-write channel the running flag carries no guaranteed meaning after the last completion.

Top module: `dma_chan_status`

## Requirements
- R1: After reset, `status_o` is 0x0000 and `done_irq_o`, `err_irq_o` and `invalidate_cur_o` are low.
- R2: A bus write to the configuration address with enable (write data bit 0) at 1 sets the running flag (status bit 3) at the next clock edge. The same write with enable at 0 clears both the running flag and the fetch flag.
- R3: The flow field of a configuration write sits in write data bits 6:4. An enabled write with flow 4, 5, 6 or 7 sets the fetch flag (status bit 2). An enabled write with flow 0 to 3 leaves the fetch flag clear.
- R4: The engine events act on the flags. Fetch start sets the fetch flag and the running flag. Fetch end clears the fetch flag. Stop clears both flags. A configuration write in the same cycle takes precedence over all three events.
- R5: The fetch and running flags are read-only. A write to the status address leaves status bits 3:2 unchanged, whatever the write data holds.
- R6: A done event sets the completion flag (status bit 0). The flag stays set until a status-address write has bit 0 at 1. Writing 0 to that bit has no effect. `done_irq_o` equals the completion flag.
- R7: An error event sets the error flag (status bit 1). The flag stays set until a status-address write has bit 1 at 1. Writing 0 to that bit has no effect. `err_irq_o` equals the error flag.
- R8: If a set event and a write-one-to-clear hit the same sticky flag in the same cycle, the flag ends up set.
- R9: `invalidate_cur_o` is high for exactly the cycle after each cycle in which the error event is high, and low otherwise.
- R10: Status bits 15:4 always read 0. Stop and configuration events do not change the sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register-bus write strobe |
| reg_addr_i | input | ADDR_W | Register-bus word address |
| reg_wdata_i | input | 16 | Register-bus write data |
| ev_done_i | input | 1 | Work unit completed |
| ev_err_i | input | 1 | DMA error detected |
| ev_fetch_start_i | input | 1 | Descriptor fetch started |
| ev_fetch_end_i | input | 1 | Descriptor fetch finished |
| ev_stop_i | input | 1 | Channel halted in stop flow mode |
| status_o | output | 16 | Status word |
| done_irq_o | output | 1 | Channel completion interrupt |
| err_irq_o | output | 1 | Contribution to the global error interrupt |
| invalidate_cur_o | output | 1 | Current-pointer registers invalid pulse |

## Verification
The bench sweeps all eight flow values through enabled configuration writes. A decoder that looks at the wrong bit, or treats flow 3 as a descriptor mode, shows a wrong fetch flag at once. It writes zero and then ones into the read-only and sticky positions. A wrong write mask would either clear a flag that should stay or fail to clear one that should go. It fires set events and clears for the same flag in one cycle, where a design with clear priority would drop a completion. It also fires configuration writes together with a stop, where an engine-first design would leave the channel halted.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned BIT_DONE  = 0;
  localparam int unsigned BIT_ERR   = 1;
  localparam int unsigned BIT_FETCH = 2;
  localparam int unsigned BIT_RUN   = 3;
  localparam int unsigned N_FLAGS   = 4;

  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned FLOW_LSB     = 4;
  localparam int unsigned FLOW_W       = 3;
  localparam int unsigned FLOW_DESC_MIN = 4;

  typedef struct packed {
    logic              cfg_wr;
    logic              cfg_en;
    logic              cfg_desc;
    logic              clr_done;
    logic              clr_err;
  } bus_dec_t;
endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
  import dma_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output bus_dec_t          dec_o
);
  logic [FLOW_W-1:0] flow;
  logic              hit_cfg, hit_stat;
  logic              unused_wdata;

  assign flow     = wdata_i[FLOW_LSB +: FLOW_W];
  assign hit_cfg  = wr_i && (addr_i == CFG_ADDR);
  assign hit_stat = wr_i && (addr_i == STAT_ADDR);
  assign unused_wdata = ^wdata_i;

  always_comb begin
    dec_o          = '0;
    dec_o.cfg_wr   = hit_cfg;
    dec_o.cfg_en   = wdata_i[CFG_EN_BIT];
    dec_o.cfg_desc = (32'(flow) >= FLOW_DESC_MIN);
    // only the sticky positions are writable; run/fetch bits ignored
    dec_o.clr_done = hit_stat && wdata_i[BIT_DONE];
    dec_o.clr_err  = hit_stat && wdata_i[BIT_ERR];
  end
endmodule

// File: rtl/dma_run_state.sv
module dma_run_state
  import dma_stat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_dec_t dec_i,
  input  logic     fetch_start_i,
  input  logic     fetch_end_i,
  input  logic     stop_i,
  output logic     run_o,
  output logic     fetch_o
);
  logic run_d, fetch_d;

  always_comb begin
    run_d   = run_o;
    fetch_d = fetch_o;
    if (dec_i.cfg_wr) begin
      // software config write overrides engine events
      run_d   = dec_i.cfg_en;
      fetch_d = dec_i.cfg_en && dec_i.cfg_desc;
    end else if (stop_i) begin
      run_d   = 1'b0;
      fetch_d = 1'b0;
    end else if (fetch_end_i) begin
      fetch_d = 1'b0;
    end else if (fetch_start_i) begin
      fetch_d = 1'b1;
      run_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      fetch_o <= 1'b0;
    end else begin
      run_o   <= run_d;
      fetch_o <= fetch_d;
    end
  end
endmodule

// File: rtl/dma_w1c_flag.sv
module dma_w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set beats clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  input  logic              ev_done_i,
  input  logic              ev_err_i,
  input  logic              ev_fetch_start_i,
  input  logic              ev_fetch_end_i,
  input  logic              ev_stop_i,
  output logic [15:0]       status_o,
  output logic              done_irq_o,
  output logic              err_irq_o,
  output logic              invalidate_cur_o
);
  bus_dec_t dec;
  logic     run_q, fetch_q;
  logic [1:0] sticky_q, sticky_set, sticky_clr;
  logic     inv_q;

  dma_bus_decode #(
    .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .dec_o(dec)
  );

  dma_run_state u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec),
    .fetch_start_i(ev_fetch_start_i), .fetch_end_i(ev_fetch_end_i),
    .stop_i(ev_stop_i), .run_o(run_q), .fetch_o(fetch_q)
  );

  assign sticky_set = {ev_err_i, ev_done_i};
  assign sticky_clr = {dec.clr_err, dec.clr_done};

  for (genvar g = 0; g < 2; g++) begin : g_sticky
    dma_w1c_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(sticky_set[g]), .clr_i(sticky_clr[g]), .q_o(sticky_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inv_q <= 1'b0;
    else         inv_q <= ev_err_i;
  end

  always_comb begin
    status_o            = '0;
    status_o[BIT_DONE]  = sticky_q[0];
    status_o[BIT_ERR]   = sticky_q[1];
    status_o[BIT_FETCH] = fetch_q;
    status_o[BIT_RUN]   = run_q;
  end

  assign done_irq_o       = sticky_q[0];
  assign err_irq_o        = sticky_q[1];
  assign invalidate_cur_o = inv_q;
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [15:0]       reg_wdata_i,
  input logic              ev_done_i,
  input logic              ev_err_i,
  input logic [15:0]       status_o,
  input logic              done_irq_o,
  input logic              err_irq_o,
  input logic              invalidate_cur_o
);
  logic cfg_w, stat_w;
  assign cfg_w  = reg_wr_i && reg_addr_i == CFG_ADDR;
  assign stat_w = reg_wr_i && reg_addr_i == STAT_ADDR;

  p_run_on_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w && reg_wdata_i[0] |=> status_o[3]);
  p_off_on_cfg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w && !reg_wdata_i[0] |=> status_o[3:2] == 2'b00);
  p_fetch_desc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_w && reg_wdata_i[0] |=> status_o[2] == $past(reg_wdata_i[6]));
  p_ro_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_w && !cfg_w |=> $stable(status_o[3:2]));
  p_done_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && !(stat_w && reg_wdata_i[0]) |=> status_o[0]);
  p_done_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o == status_o[0]);
  p_err_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o == status_o[1]);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_done_i |=> status_o[0]);
  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_i |=> status_o[1]);
  p_inv_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_err_i |=> invalidate_cur_o);
  p_inv_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_err_i |=> !invalidate_cur_o);
  p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[15:4] == '0);
endmodule

bind dma_chan_status dma_chan_status_chk #(
  .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .ev_done_i(ev_done_i), .ev_err_i(ev_err_i),
  .status_o(status_o), .done_irq_o(done_irq_o), .err_irq_o(err_irq_o),
  .invalidate_cur_o(invalidate_cur_o)
);

// File: tb/dma_chan_status_tb_top.sv
`timescale 1ns/1ps
module dma_chan_status_tb_top;
  localparam int unsigned ADDR_W = 4;
  localparam logic [ADDR_W-1:0] CFG_A  = 4'h2;
  localparam logic [ADDR_W-1:0] STAT_A = 4'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic ev_done = 0, ev_err = 0, ev_fs = 0, ev_fe = 0, ev_stop = 0;
  logic [15:0] status;
  logic done_irq, err_irq, inv;

  always #5 clk = ~clk;

  dma_chan_status #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_A), .STAT_ADDR(STAT_A)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .ev_done_i(ev_done), .ev_err_i(ev_err),
    .ev_fetch_start_i(ev_fs), .ev_fetch_end_i(ev_fe), .ev_stop_i(ev_stop),
    .status_o(status), .done_irq_o(done_irq), .err_irq_o(err_irq),
    .invalidate_cur_o(inv)
  );

  typedef struct {
    logic [15:0] st;
    logic        dirq, eirq, inv;
    string       tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  logic m_run = 0, m_fetch = 0, m_done = 0, m_err = 0;

  task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got st=%h irq/err/inv=%b expected st=%h irq/err/inv=%b",
               tag, act[18:3], act[2:0], exp[18:3], exp[2:0]);
    end
  endtask

  // driver: one active cycle, then back to idle
  task automatic step(input string tag, input bit cw, input bit en, input int flow,
                      input bit sw, input logic [15:0] swd,
                      input bit d, input bit e, input bit fs, input bit fe, input bit sp);
    exp_t x;
    @(negedge clk);
    reg_wr   = cw | sw;
    reg_addr = cw ? CFG_A : STAT_A;
    reg_wdata = cw ? (16'(flow) << 4) | 16'(en) : swd;
    ev_done = d; ev_err = e; ev_fs = fs; ev_fe = fe; ev_stop = sp;
    if (cw) begin m_run = en; m_fetch = en && flow >= 4; end
    else if (sp) begin m_run = 0; m_fetch = 0; end
    else if (fe) m_fetch = 0;
    else if (fs) begin m_fetch = 1; m_run = 1; end
    if (d) m_done = 1; else if (sw && swd[0]) m_done = 0;
    if (e) m_err = 1;  else if (sw && swd[1]) m_err = 0;
    x.st = {12'h0, m_run, m_fetch, m_err, m_done};
    x.dirq = m_done; x.eirq = m_err; x.inv = e; x.tag = tag;
    q.push_back(x);
    @(negedge clk);
    reg_wr = 0; ev_done = 0; ev_err = 0; ev_fs = 0; ev_fe = 0; ev_stop = 0;
  endtask

  // monitor: compare just after the edge that applies the step
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      check(x.tag, {status, done_irq, err_irq, inv}, {x.st, x.dirq, x.eirq, x.inv});
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #22;
    check("R1 reset", {status, done_irq, err_irq, inv}, 19'h0);
    rst_n = 1'b1;
    step("R1 idle", 0,0,0, 0,0, 0,0,0,0,0);
    step("R2 enable flow0", 1,1,0, 0,0, 0,0,0,0,0);
    step("R6 done set", 0,0,0, 0,0, 1,0,0,0,0);
    step("R10 done kept by run", 0,0,0, 0,0, 0,0,0,0,0);
    step("R6 write zero", 0,0,0, 1,16'h0000, 0,0,0,0,0);
    step("R5 ro bits", 0,0,0, 1,16'h000C, 0,0,0,0,0);
    step("R6 w1c done", 0,0,0, 1,16'h0001, 0,0,0,0,0);
    step("R3 enable flow5", 1,1,5, 0,0, 0,0,0,0,0);
    step("R4 fetch end", 0,0,0, 0,0, 0,0,0,1,0);
    step("R4 fetch start", 0,0,0, 0,0, 0,0,1,0,0);
    step("R5 ro clear try", 0,0,0, 1,16'hFFFC, 0,0,0,0,0);
    step("R4 stop", 0,0,0, 0,0, 0,0,0,0,1);
    for (int f = 0; f < 8; f++) step("R3 flow sweep", 1,1,f, 0,0, 0,0,0,0,0);
    step("R2 disable", 1,0,7, 0,0, 0,0,0,0,0);
    step("R7 err set R9 inv", 0,0,0, 0,0, 0,1,0,0,0);
    step("R9 inv drop", 0,0,0, 0,0, 0,0,0,0,0);
    step("R7 write zero", 0,0,0, 1,16'h0000, 0,0,0,0,0);
    step("R8 done set vs clr", 0,0,0, 1,16'h0001, 1,0,0,0,0);
    step("R8 err set vs clr", 0,0,0, 1,16'h0002, 0,1,0,0,0);
    step("R7 w1c both", 0,0,0, 1,16'h0003, 0,0,0,0,0);
    step("R4 cfg beats stop", 1,1,6, 0,0, 0,0,0,0,1);
    step("R10 stop keeps done", 0,0,0, 0,0, 1,0,0,0,0);
    step("R10 stop keeps done", 0,0,0, 0,0, 0,0,0,0,1);
    step("R10 upper zero", 0,0,0, 1,16'hFFF0, 0,0,0,0,0);
    step("R10 cfg keeps sticky", 1,0,0, 0,0, 0,1,0,0,0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule